// File: doc/BRIEF.md
# DS3 Receive Far-End Alarm and Error Monitor

This block sits behind a DS3 receive framer that has already found frame alignment and pulled out the overhead bits. Once per received frame the framer pulses `frame_done` and presents the two X bits, the three far-end block error bits and the application identification bit. From these the block tracks the far-end receive failure (yellow alarm), keeps the latest error and framing-format bits in a status byte, and counts far-end block error events in a saturating 16-bit counter.

Interrupt status bits are raised for changes of the yellow alarm and of the framing-format bit. Bits for conditions detected elsewhere in the receiver (loss of signal, alarm indication, idle, out of frame, parity errors) are set from pulse inputs. A byte-wide read port gives access to the status byte, the interrupt status byte and the two counter bytes. Reading the interrupt status byte clears the bits that are cleared on read. The `irq` output is high while any interrupt status bit is set.

Top module: `ds3_oh_alarm_mon`

## Requirements
- R1: After reset the status byte, the interrupt status byte, the counter and `rd_data` are all 0, and `irq` is 0.
- R2: The status byte at address 0x11 reads {3'b000, yellow alarm, AIC, FEBE[2:0]}. AIC and FEBE take the values of the most recent frame. Its contents change only on `frame_done`.
- R3: A frame whose FEBE bits are 3'b111 leaves the counter unchanged. Any other FEBE value adds one. Without `frame_done` the counter holds.
- R4: The counter stops at 0xFFFF and does not wrap.
- R5: A read of 0x58 returns counter bits 15:8 and, at the same edge, captures bits 7:0. A later read of 0x59 returns that captured byte, so the pair is coherent even if the counter moves between the two reads.
- R6: The yellow alarm is set by a frame with X bits 2'b00 and cleared by a frame with X bits 2'b11. X bits 2'b01 or 2'b10 leave it unchanged.
- R7: Interrupt status bit 3 is set whenever a frame changes the yellow alarm state.
- R8: Interrupt status bit 2 is set when a frame carries an AIC value different from the stored one. AIC 1 means C-bit parity framing and 0 means M13 framing.
- R9: Reading the interrupt status byte at 0x13 clears bits 6:0. Bit 7 is not changed by a read.
- R10: An interrupt event that arrives in the same cycle as a read of 0x13 stays set after the read.
- R11: Pulses on `los_evt`, `ais_evt`, `idle_evt`, `oof_evt` and `perr_evt` set interrupt status bits 6, 5, 4, 1 and 0. Bit 7 shows `cperr_evt` delayed by one clock.
- R12: `irq` is high exactly while at least one interrupt status bit is set.
- R13: `rd_data` is loaded at the edge that samples `rd_en`. It holds between reads. Addresses other than 0x11, 0x13, 0x58 and 0x59 read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| frame_done | input | 1 | One cycle per received frame; overhead inputs are valid with it |
| x_bits | input | 2 | The frame's two X bits |
| febe_bits | input | 3 | The frame's three far-end block error bits |
| aic_bit | input | 1 | The frame's application identification bit |
| cperr_evt | input | 1 | C-bit parity error pulse from the parity checker |
| los_evt | input | 1 | Loss-of-signal event pulse |
| ais_evt | input | 1 | Alarm indication event pulse |
| idle_evt | input | 1 | Idle pattern event pulse |
| oof_evt | input | 1 | Out-of-frame event pulse |
| perr_evt | input | 1 | P-bit parity error pulse |
| rd_en | input | 1 | Register read strobe |
| rd_addr | input | 8 | Register read address |
| rd_data | output | 8 | Read data, valid the cycle after `rd_en` |
| irq | output | 1 | OR of all interrupt status bits |

## Verification
Two collisions are checked. In the first, a read of the high counter byte falls in the same cycle as a counted frame that carries the counter from 0x00FF to 0x0100. The bench expects 0x00 and then 0xFF for the pair, not a mix of old and new bytes. In the second, a read of the interrupt status byte coincides with a new loss-of-signal pulse. The first read must return only the older pending bit, and a second read must still show the new one.

// File: rtl/ds3_oh_alarm_mon.sv
module ds3_oh_alarm_mon #(
  parameter int                ADDR_W    = 8,
  parameter int                CNT_W     = 16,
  parameter logic [ADDR_W-1:0] A_STATUS  = 'h11,
  parameter logic [ADDR_W-1:0] A_INTR    = 'h13,
  parameter logic [ADDR_W-1:0] A_CNT_HI  = 'h58,
  parameter logic [ADDR_W-1:0] A_CNT_LO  = 'h59
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              frame_done,
  input  logic [1:0]        x_bits,
  input  logic [2:0]        febe_bits,
  input  logic              aic_bit,
  input  logic              cperr_evt,
  input  logic              los_evt,
  input  logic              ais_evt,
  input  logic              idle_evt,
  input  logic              oof_evt,
  input  logic              perr_evt,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [7:0]        rd_data,
  output logic              irq
);
  localparam int HALF_W = CNT_W / 2;
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic             yel_q, aic_q, cp_q;
  logic [2:0]       febe_q;
  logic [CNT_W-1:0] cnt_q;
  logic [HALF_W-1:0] lo_snap_q;
  logic [6:0]       rur_q;
  logic             yel_nxt;
  logic [6:0]       set_v;
  logic [7:0]       rd_mux;

  always_comb begin
    yel_nxt = yel_q;
    if (frame_done && x_bits == 2'b00) yel_nxt = 1'b1;
    if (frame_done && x_bits == 2'b11) yel_nxt = 1'b0;
  end

  wire yel_chg  = frame_done && (yel_nxt != yel_q);
  wire aic_chg  = frame_done && (aic_bit != aic_q);
  wire febe_err = frame_done && (febe_bits != 3'b111);
  wire rd_intr  = rd_en && (rd_addr == A_INTR);
  wire rd_hi    = rd_en && (rd_addr == A_CNT_HI);

  assign set_v = {los_evt, ais_evt, idle_evt, yel_chg, aic_chg, oof_evt, perr_evt};
  assign irq   = cp_q | (|rur_q);

  always_comb begin
    case (rd_addr)
      A_STATUS: rd_mux = {3'b000, yel_q, aic_q, febe_q};
      A_INTR:   rd_mux = {cp_q, rur_q};
      A_CNT_HI: rd_mux = cnt_q[CNT_W-1 -: 8];
      A_CNT_LO: rd_mux = lo_snap_q[7:0];
      default:  rd_mux = 8'h00;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      yel_q     <= 1'b0;
      aic_q     <= 1'b0;
      febe_q    <= 3'b000;
      cnt_q     <= '0;
      lo_snap_q <= '0;
      rur_q     <= '0;
      cp_q      <= 1'b0;
      rd_data   <= 8'h00;
    end else begin
      if (frame_done) begin
        yel_q  <= yel_nxt;
        aic_q  <= aic_bit;
        febe_q <= febe_bits;
      end
      if (febe_err && cnt_q != CNT_MAX) cnt_q <= cnt_q + 1'b1;
      if (rd_hi) lo_snap_q <= cnt_q[HALF_W-1:0];
      rur_q <= (rd_intr ? 7'd0 : rur_q) | set_v;
      cp_q  <= cperr_evt;
      if (rd_en) rd_data <= rd_mux;
    end
  end
endmodule

// File: rtl/ds3_oh_alarm_mon_chk.sv
module ds3_oh_alarm_mon_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        frame_done,
  input logic [1:0]  x_bits,
  input logic [2:0]  febe_bits,
  input logic        aic_bit,
  input logic        los_evt,
  input logic        ais_evt,
  input logic        idle_evt,
  input logic        oof_evt,
  input logic        perr_evt,
  input logic        rd_en,
  input logic [7:0]  rd_addr,
  input logic        yel_q,
  input logic        aic_q,
  input logic [15:0] cnt_q,
  input logic [6:0]  rur_q
);
  wire quiet = !frame_done && !los_evt && !ais_evt && !idle_evt && !oof_evt && !perr_evt;

  assert_cnt_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !frame_done |=> $stable(cnt_q));
  assert_cnt_inc_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_done && febe_bits != 3'b111 && cnt_q != 16'hFFFF) |=> cnt_q == $past(cnt_q) + 16'd1);
  assert_no_overflow_R4: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q == 16'hFFFF |=> cnt_q == 16'hFFFF);
  assert_yel_set_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_done && x_bits == 2'b00) |=> yel_q);
  assert_yel_clr_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_done && x_bits == 2'b11) |=> !yel_q);
  assert_aic_int_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_done && aic_bit != aic_q) |=> rur_q[2]);
  assert_rd_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && rd_addr == 8'h13 && quiet) |=> rur_q == 7'd0);
  assert_rd_keeps_new_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && rd_addr == 8'h13 && los_evt) |=> rur_q[6]);
endmodule

bind ds3_oh_alarm_mon ds3_oh_alarm_mon_chk chk_i (
  .clk(clk), .rst_n(rst_n), .frame_done(frame_done), .x_bits(x_bits),
  .febe_bits(febe_bits), .aic_bit(aic_bit), .los_evt(los_evt), .ais_evt(ais_evt),
  .idle_evt(idle_evt), .oof_evt(oof_evt), .perr_evt(perr_evt), .rd_en(rd_en),
  .rd_addr(rd_addr), .yel_q(yel_q), .aic_q(aic_q), .cnt_q(cnt_q), .rur_q(rur_q)
);

// File: tb/ds3_oh_alarm_mon_tb.sv
module ds3_oh_alarm_mon_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic frame_done = 1'b0;
  logic [1:0] x_bits = 2'b11;
  logic [2:0] febe_bits = 3'b111;
  logic aic_bit = 1'b0;
  logic cperr_evt = 1'b0, los_evt = 1'b0, ais_evt = 1'b0;
  logic idle_evt = 1'b0, oof_evt = 1'b0, perr_evt = 1'b0;
  logic rd_en = 1'b0;
  logic [7:0] rd_addr = 8'h00;
  logic [7:0] rd_data;
  logic irq;
  int n_chk = 0, n_fail = 0;

  always #4 clk = ~clk;

  ds3_oh_alarm_mon dut_i (
    .clk(clk), .rst_n(rst_n), .frame_done(frame_done), .x_bits(x_bits),
    .febe_bits(febe_bits), .aic_bit(aic_bit), .cperr_evt(cperr_evt),
    .los_evt(los_evt), .ais_evt(ais_evt), .idle_evt(idle_evt), .oof_evt(oof_evt),
    .perr_evt(perr_evt), .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data), .irq(irq)
  );

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic frame(input logic [1:0] x, input logic [2:0] fb, input logic a);
    @(negedge clk);
    frame_done = 1'b1; x_bits = x; febe_bits = fb; aic_bit = a;
    @(negedge clk);
    frame_done = 1'b0;
  endtask

  task automatic pump(input int n, input logic [2:0] fb);
    @(negedge clk);
    frame_done = 1'b1; x_bits = 2'b11; febe_bits = fb; aic_bit = 1'b0;
    repeat (n) @(negedge clk);
    frame_done = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [7:0] d);
    @(negedge clk);
    rd_en = 1'b1; rd_addr = a;
    @(negedge clk);
    rd_en = 1'b0;
    d = rd_data;
  endtask

  task automatic t_reset;
    logic [7:0] d;
    check("R1 irq", {15'd0, irq}, 16'd0);
    check("R1 rd_data", {8'd0, rd_data}, 16'd0);
    rd(8'h11, d); check("R1 status", {8'd0, d}, 16'h00);
    rd(8'h13, d); check("R1 intr", {8'd0, d}, 16'h00);
    rd(8'h58, d); check("R1 cnt hi", {8'd0, d}, 16'h00);
    rd(8'h59, d); check("R1 cnt lo", {8'd0, d}, 16'h00);
  endtask

  task automatic t_status_aic;
    logic [7:0] d;
    frame(2'b11, 3'b101, 1'b1);
    rd(8'h11, d); check("R2 status", {8'd0, d}, 16'h0D);
    check("R12 irq set", {15'd0, irq}, 16'd1);
    rd(8'h13, d); check("R8 aic 0->1", {8'd0, d}, 16'h04);
    rd(8'h13, d); check("R9 cleared", {8'd0, d}, 16'h00);
    check("R12 irq clear", {15'd0, irq}, 16'd0);
    frame(2'b11, 3'b111, 1'b0);
    rd(8'h11, d); check("R2 status m13", {8'd0, d}, 16'h07);
    rd(8'h13, d); check("R8 aic 1->0", {8'd0, d}, 16'h04);
    rd(8'h20, d); check("R13 unmapped", {8'd0, d}, 16'h00);
    @(negedge clk); check("R13 hold", {8'd0, rd_data}, 16'h00);
  endtask

  task automatic t_yellow;
    logic [7:0] d;
    frame(2'b00, 3'b111, 1'b0);
    rd(8'h11, d); check("R6 set", {8'd0, d}, 16'h17);
    rd(8'h13, d); check("R7 set edge", {8'd0, d}, 16'h08);
    frame(2'b01, 3'b111, 1'b0);
    frame(2'b10, 3'b111, 1'b0);
    rd(8'h11, d); check("R6 hold", {8'd0, d}, 16'h17);
    rd(8'h13, d); check("R7 no change", {8'd0, d}, 16'h00);
    frame(2'b11, 3'b111, 1'b0);
    rd(8'h11, d); check("R6 clear", {8'd0, d}, 16'h07);
    rd(8'h13, d); check("R7 clear edge", {8'd0, d}, 16'h08);
  endtask

  task automatic t_febe;
    logic [7:0] d;
    frame(2'b11, 3'b000, 1'b0);
    frame(2'b11, 3'b111, 1'b0);
    frame(2'b11, 3'b110, 1'b0);
    frame(2'b11, 3'b111, 1'b0);
    frame(2'b11, 3'b011, 1'b0);
    rd(8'h58, d); check("R3 hi", {8'd0, d}, 16'h00);
    rd(8'h59, d); check("R3 count", {8'd0, d}, 16'h04);
  endtask

  task automatic t_coherent;
    logic [7:0] d;
    pump(251, 3'b000);
    @(negedge clk);
    rd_en = 1'b1; rd_addr = 8'h58;
    frame_done = 1'b1; x_bits = 2'b11; febe_bits = 3'b000; aic_bit = 1'b0;
    @(negedge clk);
    rd_en = 1'b0; frame_done = 1'b0;
    check("R5 hi old", {8'd0, rd_data}, 16'h00);
    rd(8'h59, d); check("R5 lo snap", {8'd0, d}, 16'hFF);
    rd(8'h58, d); check("R5 hi new", {8'd0, d}, 16'h01);
    rd(8'h59, d); check("R5 lo new", {8'd0, d}, 16'h00);
  endtask

  task automatic t_coincide;
    logic [7:0] d;
    @(negedge clk); ais_evt = 1'b1;
    @(negedge clk); ais_evt = 1'b0;
    rd_en = 1'b1; rd_addr = 8'h13; los_evt = 1'b1;
    @(negedge clk); rd_en = 1'b0; los_evt = 1'b0;
    check("R10 first read", {8'd0, rd_data}, 16'h20);
    rd(8'h13, d); check("R10 event kept", {8'd0, d}, 16'h40);
  endtask

  task automatic t_ext;
    logic [7:0] d;
    @(negedge clk); idle_evt = 1'b1; oof_evt = 1'b1; perr_evt = 1'b1;
    @(negedge clk); idle_evt = 1'b0; oof_evt = 1'b0; perr_evt = 1'b0;
    check("R12 irq ext", {15'd0, irq}, 16'd1);
    rd(8'h13, d); check("R11 ext bits", {8'd0, d}, 16'h13);
    check("R12 irq after read", {15'd0, irq}, 16'd0);
    @(negedge clk); cperr_evt = 1'b1;
    @(negedge clk); cperr_evt = 1'b0;
    check("R11 cp irq", {15'd0, irq}, 16'd1);
    rd_en = 1'b1; rd_addr = 8'h13;
    @(negedge clk); rd_en = 1'b0;
    check("R11 cp bit7", {8'd0, rd_data}, 16'h80);
    check("R11 cp gone", {15'd0, irq}, 16'd0);
  endtask

  task automatic t_sat;
    logic [7:0] d;
    pump(70000, 3'b010);
    rd(8'h58, d); check("R4 hi", {8'd0, d}, 16'hFF);
    rd(8'h59, d); check("R4 lo", {8'd0, d}, 16'hFF);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset;
    t_status_aic;
    t_yellow;
    t_febe;
    t_coherent;
    t_coincide;
    t_ext;
    t_sat;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule